// File: doc/BRIEF.md
# Per-Core Cache Line Coherence Controller

This block keeps the coherence state of every line in one core's direct-mapped data cache. Each line is Invalid, Shared, Exclusive or Modified. A line can also be in a transient state while a request for it is outstanding. Core accesses (load, store, evict) are checked against the tag/state array. They either finish at once or send one coherent request to the coherence manager: a shared read, an ownership read, an upgrade or a write-back.

The manager sends interventions on behalf of peer cores. Each intervention is answered one cycle later with the line's prior stable state and a flag that says whether dirty data goes with the answer. Refills arrive on a separate port, and the line is installed in the state the manager names. A completion pulse tells the core when the pending load or store has been performed. The data array, the victim choice and the thread scheduling sit outside. The core may keep issuing accesses to other lines while misses are outstanding.

Top module: `line_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. All response, request and completion outputs are low, and an intervention to any address reports Invalid (code 0) with no data.
- R2: A load to an Invalid line answers Miss (code 1) and sends a shared-read request (command 0) for its address. A fill with `fill_excl`=0 installs the line Shared. A completion with `done_store`=0 follows, and later loads to that line answer Done (code 0).
- R3: A store to an Invalid line answers Miss and sends an ownership-read request (command 1). The fill installs the line Exclusive. The store is then performed, the line becomes Modified, and the completion carries `done_store`=1.
- R4: A store to a Shared line answers Miss and sends an upgrade request (command 2). When the fill grant arrives, the line becomes Modified and the completion carries `done_store`=1.
- R5: A store to an Exclusive line answers Done, sends no request, and leaves the line Modified.
- R6: Evicting a valid matching line answers Miss and sends a write-back request (command 3). A later pull intervention (command 3) reports the pre-eviction state and carries data only if that state was Modified, after which the line is Invalid. Evicting a line that is absent answers Done with no request.
- R7: An ownership-read intervention (command 1) that hits a valid line reports its state and invalidates it. Data is attached only when the line was Modified.
- R8: A shared-read intervention (command 0) that hits a valid line leaves it Shared. Data is attached only when the line was Modified.
- R9: An upgrade intervention (command 2) that hits a valid line invalidates it.
- R10: An intervention whose tag misses, or that hits an Invalid or pending line (other than the upgrade case in R11), reports Invalid with no data and changes nothing. Every intervention is answered exactly one cycle later.
- R11: A line waiting for an upgrade grant reports Shared to interventions. An ownership-read or upgrade intervention turns it into a pending ownership read, and the later fill still completes the store as Modified.
- R12: An access to a line in a transient state answers Busy (code 2) with no request. Accesses to other lines proceed normally, and every access is answered exactly one cycle later.
- R13: A load or store whose index holds a valid line with a different tag answers Victim (code 3) with no request and no state change.
- R14: An access in the same cycle as an intervention or a fill to the same index answers Busy with no request and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Core access present |
| acc_op | input | 2 | 0 load, 1 store, 2 evict, 3 no operation |
| acc_addr | input | ADDR_W | Line address of the access |
| acc_rsp_valid | output | 1 | Access answered |
| acc_rsp_code | output | 2 | 0 Done, 1 Miss, 2 Busy, 3 Victim |
| req_valid | output | 1 | Coherent request issued |
| req_cmd | output | 2 | 0 shared read, 1 ownership read, 2 upgrade, 3 write-back |
| req_addr | output | ADDR_W | Line address of the request |
| iv_valid | input | 1 | Intervention present |
| iv_cmd | input | 2 | 0 shared read, 1 ownership read, 2 upgrade, 3 write-back pull |
| iv_addr | input | ADDR_W | Line address of the intervention |
| iv_rsp_valid | output | 1 | Intervention answered |
| iv_rsp_state | output | 2 | Prior state: 0 I, 1 S, 2 E, 3 M |
| iv_rsp_data | output | 1 | Dirty data attached |
| fill_valid | input | 1 | Refill present |
| fill_addr | input | ADDR_W | Line address of the refill |
| fill_excl | input | 1 | Load refill installs Exclusive (1) or Shared (0) |
| done_valid | output | 1 | Pending access performed |
| done_addr | output | ADDR_W | Line address of the completed access |
| done_store | output | 1 | Completed access was a store |

## Verification
The access answer, any request and the intervention answer are all registered at the first rising edge that samples their input. The bench drives each input at a falling edge and reads the results at the next falling edge. A refill completes two rising edges after it is sampled, because the store is performed one edge after installation. The bench therefore checks that no completion shows in the first cycle and that the completion fields appear in the second. Same-cycle collisions are driven together in one cycle, so both answers are checked at the same falling edge.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef enum logic [3:0] {
    LS_INV       = 4'd0,
    LS_SHD       = 4'd1,
    LS_EXC       = 4'd2,
    LS_MOD       = 4'd3,
    LS_PEND_RD   = 4'd4,
    LS_PEND_OWN  = 4'd5,
    LS_PEND_UPG  = 4'd6,
    LS_STORE_DUE = 4'd7,
    LS_WB_SHD    = 4'd8,
    LS_WB_EXC    = 4'd9,
    LS_WB_MOD    = 4'd10
  } line_state_e;

  typedef enum logic [1:0] {
    CMD_RD_SHD  = 2'd0,
    CMD_RD_OWN  = 2'd1,
    CMD_UPGRADE = 2'd2,
    CMD_WB      = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RES_DONE   = 2'd0,
    RES_MISS   = 2'd1,
    RES_BUSY   = 2'd2,
    RES_VICTIM = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    RPT_I = 2'd0,
    RPT_S = 2'd1,
    RPT_E = 2'd2,
    RPT_M = 2'd3
  } rpt_e;

  function automatic logic is_stable(line_state_e s);
    return (s == LS_SHD) || (s == LS_EXC) || (s == LS_MOD);
  endfunction

  function automatic logic is_pending(line_state_e s);
    return (s == LS_PEND_RD) || (s == LS_PEND_OWN) || (s == LS_PEND_UPG);
  endfunction

endpackage

// File: rtl/lcc_line.sv
module lcc_line
  import lcc_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_hit,
  input  logic              fill_excl,
  input  logic              snp_upd,
  input  line_state_e       snp_nxt,
  input  logic              acc_upd,
  input  line_state_e       acc_nxt,
  input  logic [TAG_W-1:0]  acc_tag,
  output line_state_e       state,
  output logic [TAG_W-1:0]  tag
);

  // Priority per line: store completion, refill, intervention, core access.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LS_INV;
      tag   <= '0;
    end else if (state == LS_STORE_DUE) begin
      state <= LS_MOD;
    end else if (fill_hit) begin
      case (state)
        LS_PEND_RD:               state <= fill_excl ? LS_EXC : LS_SHD;
        LS_PEND_OWN, LS_PEND_UPG: state <= LS_STORE_DUE;
        default:                  state <= state;
      endcase
    end else if (snp_upd) begin
      state <= snp_nxt;
    end else if (acc_upd) begin
      state <= acc_nxt;
      tag   <= acc_tag;
    end
  end

endmodule

// File: rtl/lcc_access.sv
module lcc_access
  import lcc_pkg::*;
(
  input  op_e         op,
  input  line_state_e st,
  input  logic        tag_eq,
  input  logic        clash,
  output res_e        res,
  output logic        fire,
  output cmd_e        cmd,
  output logic        upd,
  output line_state_e nxt
);

  logic stable;
  assign stable = is_stable(st);

  always_comb begin
    res  = RES_DONE;
    fire = 1'b0;
    cmd  = CMD_RD_SHD;
    upd  = 1'b0;
    nxt  = st;
    if (op != OP_NONE) begin
      if (clash || (!stable && st != LS_INV)) begin
        res = RES_BUSY;
      end else begin
        case (op)
          OP_LOAD: begin
            if (tag_eq && stable) begin
              res = RES_DONE;
            end else if (st == LS_INV) begin
              res = RES_MISS; fire = 1'b1; cmd = CMD_RD_SHD;
              upd = 1'b1; nxt = LS_PEND_RD;
            end else begin
              res = RES_VICTIM;
            end
          end
          OP_STORE: begin
            if (tag_eq && st == LS_MOD) begin
              res = RES_DONE;
            end else if (tag_eq && st == LS_EXC) begin
              upd = 1'b1; nxt = LS_MOD;
            end else if (tag_eq && st == LS_SHD) begin
              res = RES_MISS; fire = 1'b1; cmd = CMD_UPGRADE;
              upd = 1'b1; nxt = LS_PEND_UPG;
            end else if (st == LS_INV) begin
              res = RES_MISS; fire = 1'b1; cmd = CMD_RD_OWN;
              upd = 1'b1; nxt = LS_PEND_OWN;
            end else begin
              res = RES_VICTIM;
            end
          end
          OP_EVICT: begin
            if (tag_eq && stable) begin
              res = RES_MISS; fire = 1'b1; cmd = CMD_WB; upd = 1'b1;
              nxt = (st == LS_SHD) ? LS_WB_SHD :
                    (st == LS_EXC) ? LS_WB_EXC : LS_WB_MOD;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/lcc_snoop.sv
module lcc_snoop
  import lcc_pkg::*;
(
  input  cmd_e        cmd,
  input  line_state_e st,
  input  logic        tag_eq,
  output rpt_e        rpt,
  output logic        data,
  output logic        upd,
  output line_state_e nxt
);

  always_comb begin
    rpt  = RPT_I;
    data = 1'b0;
    upd  = 1'b0;
    nxt  = st;
    if (tag_eq) begin
      case (st)
        LS_SHD, LS_EXC, LS_MOD: begin
          rpt = (st == LS_SHD) ? RPT_S : (st == LS_EXC) ? RPT_E : RPT_M;
          if (cmd != CMD_WB) begin
            data = (st == LS_MOD);
            upd  = 1'b1;
            nxt  = (cmd == CMD_RD_SHD) ? LS_SHD : LS_INV;
          end
        end
        LS_PEND_UPG: begin
          rpt = RPT_S;
          if (cmd == CMD_RD_OWN || cmd == CMD_UPGRADE) begin
            upd = 1'b1;
            nxt = LS_PEND_OWN;
          end
        end
        LS_WB_SHD, LS_WB_EXC, LS_WB_MOD: begin
          if (cmd == CMD_WB) begin
            rpt  = (st == LS_WB_SHD) ? RPT_S : (st == LS_WB_EXC) ? RPT_E : RPT_M;
            data = (st == LS_WB_MOD);
            upd  = 1'b1;
            nxt  = LS_INV;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/line_coh_ctrl.sv
module line_coh_ctrl
  import lcc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_rsp_valid,
  output logic [1:0]        acc_rsp_code,
  output logic              req_valid,
  output logic [1:0]        req_cmd,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              iv_valid,
  input  logic [1:0]        iv_cmd,
  input  logic [ADDR_W-1:0] iv_addr,
  output logic              iv_rsp_valid,
  output logic [1:0]        iv_rsp_state,
  output logic              iv_rsp_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_excl,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_addr,
  output logic              done_store
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  line_state_e      st_q [LINES];
  logic [TAG_W-1:0] tg_q [LINES];

  logic [IDX_W-1:0] a_idx, s_idx, f_idx;
  logic [TAG_W-1:0] a_tag, s_tag, f_tag;
  assign a_idx = acc_addr[IDX_W-1:0];
  assign s_idx = iv_addr[IDX_W-1:0];
  assign f_idx = fill_addr[IDX_W-1:0];
  assign a_tag = acc_addr[ADDR_W-1:IDX_W];
  assign s_tag = iv_addr[ADDR_W-1:IDX_W];
  assign f_tag = fill_addr[ADDR_W-1:IDX_W];

  line_state_e a_st, s_st, f_st;
  assign a_st = st_q[a_idx];
  assign s_st = st_q[s_idx];
  assign f_st = st_q[f_idx];

  logic a_clash, fill_take;
  assign a_clash   = (iv_valid && s_idx == a_idx) || (fill_valid && f_idx == a_idx);
  assign fill_take = fill_valid && (tg_q[f_idx] == f_tag) && is_pending(f_st);

  res_e        a_res;
  logic        a_fire, a_upd;
  cmd_e        a_cmd;
  line_state_e a_nxt;

  lcc_access u_access (
    .op     (op_e'(acc_op)),
    .st     (a_st),
    .tag_eq (tg_q[a_idx] == a_tag),
    .clash  (a_clash),
    .res    (a_res),
    .fire   (a_fire),
    .cmd    (a_cmd),
    .upd    (a_upd),
    .nxt    (a_nxt)
  );

  rpt_e        s_rpt;
  logic        s_data, s_upd;
  line_state_e s_nxt;

  lcc_snoop u_snoop (
    .cmd    (cmd_e'(iv_cmd)),
    .st     (s_st),
    .tag_eq (tg_q[s_idx] == s_tag),
    .rpt    (s_rpt),
    .data   (s_data),
    .upd    (s_upd),
    .nxt    (s_nxt)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lcc_line #(.TAG_W(TAG_W)) u_line (
      .clk       (clk),
      .rst       (rst),
      .fill_hit  (fill_take && f_idx == IDX_W'(g)),
      .fill_excl (fill_excl),
      .snp_upd   (iv_valid && s_upd && s_idx == IDX_W'(g)),
      .snp_nxt   (s_nxt),
      .acc_upd   (acc_valid && a_upd && a_idx == IDX_W'(g)),
      .acc_nxt   (a_nxt),
      .acc_tag   (a_tag),
      .state     (st_q[g]),
      .tag       (tg_q[g])
    );
  end

  logic              fq_valid, fq_store;
  logic [ADDR_W-1:0] fq_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rsp_valid <= 1'b0;
      acc_rsp_code  <= '0;
      req_valid     <= 1'b0;
      req_cmd       <= '0;
      req_addr      <= '0;
      iv_rsp_valid  <= 1'b0;
      iv_rsp_state  <= '0;
      iv_rsp_data   <= 1'b0;
      fq_valid      <= 1'b0;
      fq_store      <= 1'b0;
      fq_addr       <= '0;
      done_valid    <= 1'b0;
      done_store    <= 1'b0;
      done_addr     <= '0;
    end else begin
      acc_rsp_valid <= acc_valid;
      acc_rsp_code  <= acc_valid ? a_res : RES_DONE;
      req_valid     <= acc_valid && a_fire;
      if (acc_valid && a_fire) begin
        req_cmd  <= a_cmd;
        req_addr <= acc_addr;
      end
      iv_rsp_valid  <= iv_valid;
      iv_rsp_state  <= iv_valid ? s_rpt : RPT_I;
      iv_rsp_data   <= iv_valid && s_data;
      fq_valid      <= fill_take;
      fq_store      <= (f_st != LS_PEND_RD);
      fq_addr       <= fill_addr;
      done_valid    <= fq_valid;
      done_store    <= fq_valid && fq_store;
      done_addr     <= fq_addr;
    end
  end

endmodule

// File: rtl/lcc_checks.sv
module lcc_checks
  import lcc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_rsp_valid,
  input logic [1:0] acc_rsp_code,
  input logic       req_valid,
  input logic       iv_valid,
  input logic       iv_rsp_valid,
  input logic [1:0] iv_rsp_state,
  input logic       iv_rsp_data,
  input logic       fill_valid,
  input logic       done_valid
);

  assert_req_only_on_miss_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (acc_rsp_valid && acc_rsp_code == RES_MISS));

  assert_done_after_fill_R3: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(fill_valid, 2));

  assert_data_only_dirty_R7: assert property (@(posedge clk) disable iff (rst)
    iv_rsp_data |-> (iv_rsp_valid && iv_rsp_state == RPT_M));

  assert_iv_answered_R10: assert property (@(posedge clk) disable iff (rst)
    iv_rsp_valid == $past(iv_valid));

  assert_acc_answered_R12: assert property (@(posedge clk) disable iff (rst)
    acc_rsp_valid == $past(acc_valid));

endmodule

bind line_coh_ctrl lcc_checks u_checks (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_rsp_valid (acc_rsp_valid),
  .acc_rsp_code  (acc_rsp_code),
  .req_valid     (req_valid),
  .iv_valid      (iv_valid),
  .iv_rsp_valid  (iv_rsp_valid),
  .iv_rsp_state  (iv_rsp_state),
  .iv_rsp_data   (iv_rsp_data),
  .fill_valid    (fill_valid),
  .done_valid    (done_valid)
);

// File: tb/line_coh_ctrl_tb.sv
module line_coh_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_op = '0;
  logic [9:0] acc_addr = '0;
  logic       acc_rsp_valid;
  logic [1:0] acc_rsp_code;
  logic       req_valid;
  logic [1:0] req_cmd;
  logic [9:0] req_addr;
  logic       iv_valid = 1'b0;
  logic [1:0] iv_cmd = '0;
  logic [9:0] iv_addr = '0;
  logic       iv_rsp_valid;
  logic [1:0] iv_rsp_state;
  logic       iv_rsp_data;
  logic       fill_valid = 1'b0;
  logic [9:0] fill_addr = '0;
  logic       fill_excl = 1'b0;
  logic       done_valid;
  logic [9:0] done_addr;
  logic       done_store;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_coh_ctrl u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  // Model: 0 I,1 S,2 E,3 M,4 pend load,5 pend own,6 pend upgrade,7/8/9 evicting S/E/M
  int       mst [8];
  logic [6:0] mtg [8];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic exp_acc(int op, logic [9:0] a, output int res, output int rv, output int rc);
    int i; int s; bit m;
    i = int'(a[2:0]); s = mst[i]; m = (mtg[i] == a[9:3]);
    res = 0; rv = 0; rc = 0;
    if (op == 3) return;
    if (s >= 4) begin res = 2; return; end
    case (op)
      0: if (m && s != 0) res = 0;
         else if (s == 0) begin res = 1; rv = 1; rc = 0; mst[i] = 4; mtg[i] = a[9:3]; end
         else res = 3;
      1: if (m && s == 3) res = 0;
         else if (m && s == 2) begin res = 0; mst[i] = 3; end
         else if (m && s == 1) begin res = 1; rv = 1; rc = 2; mst[i] = 6; end
         else if (s == 0) begin res = 1; rv = 1; rc = 1; mst[i] = 5; mtg[i] = a[9:3]; end
         else res = 3;
      default: if (m && s != 0) begin res = 1; rv = 1; rc = 3; mst[i] = 6 + s; end
    endcase
  endtask

  task automatic exp_iv(int cmd, logic [9:0] a, output int rp, output int dt);
    int i; int s;
    i = int'(a[2:0]); s = mst[i];
    rp = 0; dt = 0;
    if (mtg[i] != a[9:3]) return;
    if (s >= 1 && s <= 3) begin
      rp = s;
      if (cmd != 3) begin dt = (s == 3); mst[i] = (cmd == 0) ? 1 : 0; end
    end else if (s == 6) begin
      rp = 1;
      if (cmd == 1 || cmd == 2) mst[i] = 5;
    end else if (s >= 7 && cmd == 3) begin
      rp = s - 6; dt = (s == 9); mst[i] = 0;
    end
  endtask

  task automatic exp_fill(logic [9:0] a, bit excl, output int take, output int st);
    int i; int s;
    i = int'(a[2:0]); s = mst[i];
    take = 0; st = 0;
    if (mtg[i] == a[9:3] && s >= 4 && s <= 6) begin
      take = 1; st = (s != 4);
      mst[i] = (s == 4) ? (excl ? 2 : 1) : 3;
    end
  endtask

  task automatic do_acc(int op, logic [9:0] a, string rq);
    int res, rv, rc;
    exp_acc(op, a, res, rv, rc);
    acc_valid = 1'b1; acc_op = 2'(op); acc_addr = a;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    chk(rq, "acc_rsp_valid", int'(acc_rsp_valid), 1);
    chk(rq, "acc_rsp_code", int'(acc_rsp_code), res);
    chk(rq, "req_valid", int'(req_valid), rv);
    if (rv != 0) begin
      chk(rq, "req_cmd", int'(req_cmd), rc);
      chk(rq, "req_addr", int'(req_addr), int'(a));
    end
  endtask

  task automatic do_iv(int cmd, logic [9:0] a, string rq);
    int rp, dt;
    exp_iv(cmd, a, rp, dt);
    iv_valid = 1'b1; iv_cmd = 2'(cmd); iv_addr = a;
    @(posedge clk); @(negedge clk);
    iv_valid = 1'b0;
    chk(rq, "iv_rsp_valid", int'(iv_rsp_valid), 1);
    chk(rq, "iv_rsp_state", int'(iv_rsp_state), rp);
    chk(rq, "iv_rsp_data", int'(iv_rsp_data), dt);
  endtask

  task automatic do_fill(logic [9:0] a, bit excl, string rq);
    int take, st;
    exp_fill(a, excl, take, st);
    fill_valid = 1'b1; fill_addr = a; fill_excl = excl;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk(rq, "done_valid early", int'(done_valid), 0);
    @(posedge clk); @(negedge clk);
    chk(rq, "done_valid", int'(done_valid), take);
    if (take != 0) begin
      chk(rq, "done_addr", int'(done_addr), int'(a));
      chk(rq, "done_store", int'(done_store), st);
    end
  endtask

  // Access and intervention to the same index in one cycle
  task automatic clash_iv(int op, logic [9:0] a, int cmd, logic [9:0] b, string rq);
    int rp, dt;
    exp_iv(cmd, b, rp, dt);
    acc_valid = 1'b1; acc_op = 2'(op); acc_addr = a;
    iv_valid = 1'b1; iv_cmd = 2'(cmd); iv_addr = b;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0; iv_valid = 1'b0;
    chk(rq, "acc_rsp_code", int'(acc_rsp_code), 2);
    chk(rq, "req_valid", int'(req_valid), 0);
    chk(rq, "iv_rsp_state", int'(iv_rsp_state), rp);
    chk(rq, "iv_rsp_data", int'(iv_rsp_data), dt);
  endtask

  task automatic clash_fill(int op, logic [9:0] a, logic [9:0] b, string rq);
    int take, st;
    exp_fill(b, 1'b0, take, st);
    acc_valid = 1'b1; acc_op = 2'(op); acc_addr = a;
    fill_valid = 1'b1; fill_addr = b; fill_excl = 1'b0;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0; fill_valid = 1'b0;
    chk(rq, "acc_rsp_code", int'(acc_rsp_code), 2);
    chk(rq, "req_valid", int'(req_valid), 0);
    @(posedge clk); @(negedge clk);
    chk(rq, "done_valid", int'(done_valid), take);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mtg[i] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);

    // R1: reset state
    chk("R1", "acc_rsp_valid", int'(acc_rsp_valid), 0);
    chk("R1", "req_valid", int'(req_valid), 0);
    chk("R1", "iv_rsp_valid", int'(iv_rsp_valid), 0);
    chk("R1", "done_valid", int'(done_valid), 0);
    do_iv(0, 10'h005, "R1");
    do_iv(1, 10'h3fe, "R1");

    // R2 and R12: load miss, hit under miss, refill
    do_acc(0, 10'h011, "R2");
    do_acc(0, 10'h011, "R12");
    do_acc(1, 10'h012, "R12");
    do_fill(10'h011, 1'b0, "R2");
    do_acc(0, 10'h011, "R2");
    do_iv(0, 10'h011, "R8");

    // R3, R8, R4, R11, R7
    do_fill(10'h012, 1'b0, "R3");
    do_acc(1, 10'h012, "R3");
    do_iv(0, 10'h012, "R8");
    do_acc(1, 10'h012, "R4");
    do_iv(1, 10'h012, "R11");
    do_acc(0, 10'h012, "R12");
    do_fill(10'h012, 1'b0, "R11");
    do_iv(1, 10'h012, "R7");
    do_acc(0, 10'h00b, "R4");
    do_fill(10'h00b, 1'b0, "R4");
    do_acc(1, 10'h00b, "R4");
    do_fill(10'h00b, 1'b1, "R4");
    do_iv(2, 10'h00b, "R9");

    // R5, R9
    do_acc(0, 10'h013, "R5");
    do_fill(10'h013, 1'b1, "R5");
    do_acc(1, 10'h013, "R5");
    do_iv(2, 10'h013, "R9");
    do_acc(0, 10'h014, "R9");
    do_fill(10'h014, 1'b0, "R9");
    do_iv(2, 10'h014, "R9");
    do_acc(0, 10'h014, "R9");

    // R13, R10
    do_acc(0, 10'h015, "R13");
    do_fill(10'h015, 1'b1, "R13");
    do_acc(0, 10'h025, "R13");
    do_acc(1, 10'h025, "R13");
    do_iv(1, 10'h025, "R10");
    do_acc(0, 10'h015, "R13");

    // R6
    do_acc(2, 10'h015, "R6");
    do_acc(0, 10'h015, "R12");
    do_iv(0, 10'h015, "R10");
    do_iv(3, 10'h015, "R6");
    do_acc(2, 10'h015, "R6");
    do_acc(1, 10'h016, "R6");
    do_fill(10'h016, 1'b0, "R6");
    do_acc(2, 10'h016, "R6");
    do_iv(3, 10'h016, "R6");

    // R7 on a clean line
    do_acc(0, 10'h017, "R7");
    do_fill(10'h017, 1'b1, "R7");
    do_iv(1, 10'h017, "R7");

    // R14: same-index collisions
    clash_iv(0, 10'h011, 0, 10'h011, "R14");
    clash_fill(0, 10'h011, 10'h011, "R14");
    do_acc(0, 10'h011, "R14");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      int kind;
      logic [9:0] a;
      a = {7'($urandom % 3), 3'($urandom % 8)};
      kind = int'($urandom % 10);
      if (kind < 5) begin
        do_acc(int'($urandom % 4), a, "R12");
      end else if (kind < 8) begin
        do_iv(int'($urandom % 4), a, "R10");
      end else begin
        for (int k = 0; k < 8; k++) begin
          if (mst[k] >= 4 && mst[k] <= 6) begin
            a = {mtg[k], 3'(k)};
            break;
          end
        end
        do_fill(a, 1'($urandom % 2), "R3");
      end
    end

    summary();
    $finish;
  end

endmodule